// File: doc/BRIEF.md
# Serial NAND Bad-Block Scanner

This block walks every erase block of a serial NAND device once after start-up and records in flip-flops which blocks are unusable. For each block it issues a page-load frame for the block's first page, polls the status register until the device reports ready, and then fetches sixteen bytes of the spare area. Two marker rules decide the verdict. The first is a factory mark: the first spare byte is not 0xFF. The second is a user signature: the four bytes at spare offset 8 spell DE AD BE EF.

The block talks to the device through a byte-transaction port. A frame is the span during which `spi_cs` is high. Inside a frame each byte is offered on `spi_tx` with `spi_req` and completed by a one-cycle `spi_ack`, which returns the byte received in the same exchange on `spi_rx`. Downstream logic reads the bitmap and the count once `scan_done` rises. If `scan_err` rises instead, the device stayed busy and the scan stopped.

Top module: `nbs_bbt_scanner`

## Requirements
- R1: A `start` pulse while idle clears `bad_map`, `bad_count`, `scan_done` and `scan_err` at the same edge and raises `scan_busy`. A `start` pulse while `scan_busy` is high has no effect on the scan or its result.
- R2: Blocks are visited in ascending order from 0. Each visit opens with the frame 0x13, 0x00, row[15:8], row[7:0], where row = block number shifted left by 6.
- R3: After a page load, status frames of 0x0F, 0xC0 followed by one received byte repeat while bit 0 of the received byte is 1. Only bit 0 matters. The spare read starts only after a status byte with bit 0 clear, and a ready answer on the 100th poll is still accepted.
- R4: The spare read is the frame 0x03, 0x08, 0x00, 0x00 followed by exactly 16 received bytes, one such frame per visited block.
- R5: When received spare byte 0 differs from 0xFF, bit j of `bad_map` (block j) is set, whatever bytes 8 to 11 hold.
- R6: When spare byte 0 is 0xFF, block j is marked bad only if bytes 8, 9, 10 and 11, in arrival order, are exactly 0xDE, 0xAD, 0xBE, 0xEF. A partial, reversed or altered signature leaves the bit clear.
- R7: `bad_count` equals the number of set bits in `bad_map`. A block carrying both markers counts once.
- R8: If bit 0 is still 1 on the 100th status poll of a block, the scan stops: `scan_err` goes high, `scan_done` stays low, `scan_busy` falls, and no further frame is issued. Verdicts of earlier blocks are kept.
- R9: `scan_done` rises only after the last block's verdict is stored, in the same cycle `scan_busy` falls, and is never high while `scan_busy` is high.
- R10: `spi_tx` and `spi_req` hold steady until `spi_ack`. `spi_cs` stays low for at least one cycle between frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Scan start strobe |
| spi_cs | output | 1 | Frame select, high for the whole frame |
| spi_req | output | 1 | Byte request |
| spi_tx | output | 8 | Byte to send |
| spi_ack | input | 1 | One-cycle byte completion |
| spi_rx | input | 8 | Byte received with the acknowledged exchange |
| bad_map | output | NUM_BLOCKS | One bit per block, 1 = bad |
| bad_count | output | clog2(NUM_BLOCKS+1) | Number of bad blocks found |
| scan_busy | output | 1 | Scan in progress |
| scan_done | output | 1 | All blocks evaluated |
| scan_err | output | 1 | Scan stopped on a device that stayed busy |

## Verification
The hardest situation to reach is the poll limit: the device must answer busy on exactly the right number of consecutive polls for one chosen block. The bench's device model holds a per-block busy budget. One block answers busy 99 times and then ready, which must still be accepted. Another answers busy 100 times, which must stop the scan with earlier verdicts intact and no further frames. The signature rule is driven with near-miss patterns (reversed, one byte altered, paired with a factory mark) so that only an exact, in-order match sets a bit.

// File: rtl/nbs_pkg.sv
// Shared types and frame constants for the bad-block scanner.
package nbs_pkg;

    typedef enum logic [1:0] {
        FK_LOAD  = 2'd0,
        FK_POLL  = 2'd1,
        FK_SPARE = 2'd2
    } frame_kind_t;

    localparam logic [7:0] OP_PAGE_LOAD  = 8'h13;
    localparam logic [7:0] OP_REG_READ   = 8'h0F;
    localparam logic [7:0] OP_CACHE_READ = 8'h03;
    localparam logic [7:0] REG_STATUS    = 8'hC0;
    localparam logic [7:0] SPARE_COL_HI  = 8'h08;
    localparam logic [7:0] FILL_BYTE     = 8'h00;
    localparam logic [7:0] BLANK_BYTE    = 8'hFF;

    localparam int          ROW_W       = 16;
    localparam int          IDX_W       = 5;
    localparam int          SPARE_BYTES = 16;
    localparam int          SIG_OFFSET  = 8;
    localparam logic [31:0] SIG_WORD    = 32'hDEADBEEF;

    // Bytes sent before the receive phase of a frame.
    function automatic logic [IDX_W-1:0] fk_tx_len(frame_kind_t k);
        case (k)
            FK_POLL: return 5'd2;
            default: return 5'd4;
        endcase
    endfunction

    // Bytes received after the send phase of a frame.
    function automatic logic [IDX_W-1:0] fk_rx_len(frame_kind_t k);
        case (k)
            FK_LOAD: return 5'd0;
            FK_POLL: return 5'd1;
            default: return IDX_W'(SPARE_BYTES);
        endcase
    endfunction

endpackage

// File: rtl/nbs_frame_engine.sv
// Runs one frame on the byte-transaction port: raises the frame select,
// offers each byte until acknowledged, reports received bytes with their
// index inside the receive phase, then drops the select for one gap cycle
// and pulses f_done. Assumes row is held stable for the frame.
module nbs_frame_engine
    import nbs_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                go,
    input  frame_kind_t         kind,
    input  logic [ROW_W-1:0]    row,
    output logic                f_done,
    output logic                rx_valid,
    output logic [IDX_W-1:0]    rx_idx,
    output logic [7:0]          rx_data,
    output logic                spi_cs,
    output logic                spi_req,
    output logic [7:0]          spi_tx,
    input  logic                spi_ack,
    input  logic [7:0]          spi_rx
);

    typedef enum logic [1:0] {E_IDLE, E_XFER, E_GAP} eng_state_t;

    eng_state_t       state;
    frame_kind_t      kind_q;
    logic [IDX_W-1:0] idx;
    logic [IDX_W-1:0] tx_n;
    logic [IDX_W-1:0] last_idx;

    assign tx_n     = fk_tx_len(kind_q);
    assign last_idx = tx_n + fk_rx_len(kind_q) - 5'd1;

    // Frame sequencing: accept go, step the byte index on each ack.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= E_IDLE;
            kind_q <= FK_LOAD;
            idx    <= '0;
        end else begin
            case (state)
                E_IDLE: if (go) begin
                    state  <= E_XFER;
                    kind_q <= kind;
                    idx    <= '0;
                end
                E_XFER: if (spi_ack) begin
                    if (idx == last_idx) state <= E_GAP;
                    else                 idx   <= idx + 5'd1;
                end
                default: state <= E_IDLE;
            endcase
        end
    end

    // Byte to send for the current kind and index.
    always_comb begin
        spi_tx = FILL_BYTE;
        case (kind_q)
            FK_LOAD: begin
                case (idx)
                    5'd0:    spi_tx = OP_PAGE_LOAD;
                    5'd2:    spi_tx = row[15:8];
                    5'd3:    spi_tx = row[7:0];
                    default: spi_tx = FILL_BYTE;
                endcase
            end
            FK_POLL: begin
                case (idx)
                    5'd0:    spi_tx = OP_REG_READ;
                    5'd1:    spi_tx = REG_STATUS;
                    default: spi_tx = FILL_BYTE;
                endcase
            end
            default: begin
                case (idx)
                    5'd0:    spi_tx = OP_CACHE_READ;
                    5'd1:    spi_tx = SPARE_COL_HI;
                    default: spi_tx = FILL_BYTE;
                endcase
            end
        endcase
    end

    assign spi_cs   = (state == E_XFER);
    assign spi_req  = (state == E_XFER);
    assign f_done   = (state == E_GAP);
    assign rx_valid = (state == E_XFER) && spi_ack && (idx >= tx_n);
    assign rx_idx   = idx - tx_n;
    assign rx_data  = spi_rx;

    p_tx_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_req && !spi_ack) |=> (spi_req && $stable(spi_tx)));

    p_cs_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(spi_cs) |=> !spi_cs);

endmodule

// File: rtl/nbs_marker_check.sv
// Judges one spare-area read: flags a factory mark when byte 0 is not
// blank, and matches the four signature bytes in arrival order. Assumes
// clr is pulsed before each spare frame.
module nbs_marker_check
    import nbs_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             rx_valid,
    input  logic [IDX_W-1:0] rx_idx,
    input  logic [7:0]       rx_data,
    output logic             blk_bad
);

    logic       factory_bad;
    logic [3:0] sig_hit;

    // Factory mark: first spare byte differs from the erased value.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            factory_bad <= 1'b0;
        else if (rx_valid && rx_idx == '0 && rx_data != BLANK_BYTE)
            factory_bad <= 1'b1;
    end

    // One matcher per signature byte, each tied to its own offset.
    for (genvar g = 0; g < 4; g++) begin : g_sig
        localparam logic [IDX_W-1:0] POS = IDX_W'(SIG_OFFSET + g);
        localparam logic [7:0]       VAL = SIG_WORD[31-8*g -: 8];
        always_ff @(posedge clk) begin
            if (!rst_n || clr)
                sig_hit[g] <= 1'b0;
            else if (rx_valid && rx_idx == POS)
                sig_hit[g] <= (rx_data == VAL);
        end
    end

    assign blk_bad = factory_bad | (&sig_hit);

endmodule

// File: rtl/nbs_bad_map.sv
// Holds the per-block verdict bits and the running bad-block count.
// Assumes each block is written at most once between clears.
module nbs_bad_map #(
    parameter int NUM_BLOCKS = 1024,
    parameter int BLK_W      = $clog2(NUM_BLOCKS),
    parameter int CNT_W      = $clog2(NUM_BLOCKS + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr,
    input  logic                  wr_en,
    input  logic [BLK_W-1:0]      wr_idx,
    input  logic                  wr_bad,
    output logic [NUM_BLOCKS-1:0] bad_map,
    output logic [CNT_W-1:0]      bad_count
);

    for (genvar g = 0; g < NUM_BLOCKS; g++) begin : g_bit
        // Store the verdict of block g when it is evaluated.
        always_ff @(posedge clk) begin
            if (!rst_n || clr)
                bad_map[g] <= 1'b0;
            else if (wr_en && wr_idx == BLK_W'(g))
                bad_map[g] <= wr_bad;
        end
    end

    // Count every bad verdict written.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            bad_count <= '0;
        else if (wr_en && wr_bad)
            bad_count <= bad_count + 1'b1;
    end

endmodule

// File: rtl/nbs_bbt_scanner.sv
// Top of the bad-block scanner: on start, visits every block in order with
// page load, status polling and spare read, and records the verdicts.
// Assumes the device answers each byte request with a one-cycle ack.
module nbs_bbt_scanner
    import nbs_pkg::*;
#(
    parameter int NUM_BLOCKS  = 1024,
    parameter int PAGES_SHIFT = 6,
    parameter int POLL_LIMIT  = 100
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            start,
    output logic                            spi_cs,
    output logic                            spi_req,
    output logic [7:0]                      spi_tx,
    input  logic                            spi_ack,
    input  logic [7:0]                      spi_rx,
    output logic [NUM_BLOCKS-1:0]           bad_map,
    output logic [$clog2(NUM_BLOCKS+1)-1:0] bad_count,
    output logic                            scan_busy,
    output logic                            scan_done,
    output logic                            scan_err
);

    localparam int BLK_W  = $clog2(NUM_BLOCKS);
    localparam int CNT_W  = $clog2(NUM_BLOCKS + 1);
    localparam int POLL_W = $clog2(POLL_LIMIT + 1);
    localparam logic [BLK_W-1:0] LAST_BLK = BLK_W'(NUM_BLOCKS - 1);

    typedef enum logic [2:0] {
        S_IDLE, S_LOAD, S_LOAD_W, S_POLL, S_POLL_W, S_SPARE, S_SPARE_W, S_EVAL
    } scan_state_t;

    scan_state_t       state;
    logic [BLK_W-1:0]  blk;
    logic [POLL_W-1:0] polls;
    logic [POLL_W-1:0] polls_n;
    logic              stat_busy;
    logic [ROW_W-1:0]  row_addr;
    frame_kind_t       kind;
    logic              go;
    logic              f_done;
    logic              rx_valid;
    logic [IDX_W-1:0]  rx_idx;
    logic [7:0]        rx_data;
    logic              blk_bad;
    logic              map_clr;

    assign row_addr  = ROW_W'(blk) << PAGES_SHIFT;
    assign polls_n   = polls + POLL_W'(1);
    assign go        = (state == S_LOAD) || (state == S_POLL) || (state == S_SPARE);
    assign map_clr   = (state == S_IDLE) && start;
    assign scan_busy = (state != S_IDLE);

    // Frame kind requested by the current step.
    always_comb begin
        case (state)
            S_POLL:  kind = FK_POLL;
            S_SPARE: kind = FK_SPARE;
            default: kind = FK_LOAD;
        endcase
    end

    // Scan control: per-block load, poll loop, spare read and verdict.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            blk       <= '0;
            polls     <= '0;
            scan_done <= 1'b0;
            scan_err  <= 1'b0;
        end else begin
            case (state)
                S_IDLE: if (start) begin
                    blk       <= '0;
                    scan_done <= 1'b0;
                    scan_err  <= 1'b0;
                    state     <= S_LOAD;
                end
                S_LOAD:   state <= S_LOAD_W;
                S_LOAD_W: if (f_done) begin
                    polls <= '0;
                    state <= S_POLL;
                end
                S_POLL:   state <= S_POLL_W;
                S_POLL_W: if (f_done) begin
                    if (!stat_busy) begin
                        state <= S_SPARE;
                    end else if (polls_n == POLL_W'(POLL_LIMIT)) begin
                        scan_err <= 1'b1;
                        state    <= S_IDLE;
                    end else begin
                        polls <= polls_n;
                        state <= S_POLL;
                    end
                end
                S_SPARE:   state <= S_SPARE_W;
                S_SPARE_W: if (f_done) state <= S_EVAL;
                S_EVAL: begin
                    if (blk == LAST_BLK) begin
                        scan_done <= 1'b1;
                        state     <= S_IDLE;
                    end else begin
                        blk   <= blk + 1'b1;
                        state <= S_LOAD;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // Capture the ready bit of each status answer.
    always_ff @(posedge clk) begin
        if (!rst_n)
            stat_busy <= 1'b0;
        else if (state == S_POLL_W && rx_valid)
            stat_busy <= rx_data[0];
    end

    nbs_frame_engine u_engine (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (go),
        .kind     (kind),
        .row      (row_addr),
        .f_done   (f_done),
        .rx_valid (rx_valid),
        .rx_idx   (rx_idx),
        .rx_data  (rx_data),
        .spi_cs   (spi_cs),
        .spi_req  (spi_req),
        .spi_tx   (spi_tx),
        .spi_ack  (spi_ack),
        .spi_rx   (spi_rx)
    );

    nbs_marker_check u_marker (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (state == S_SPARE),
        .rx_valid (rx_valid && state == S_SPARE_W),
        .rx_idx   (rx_idx),
        .rx_data  (rx_data),
        .blk_bad  (blk_bad)
    );

    nbs_bad_map #(
        .NUM_BLOCKS (NUM_BLOCKS),
        .BLK_W      (BLK_W),
        .CNT_W      (CNT_W)
    ) u_map (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (map_clr),
        .wr_en     (state == S_EVAL),
        .wr_idx    (blk),
        .wr_bad    (blk_bad),
        .bad_map   (bad_map),
        .bad_count (bad_count)
    );

    p_spare_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_SPARE) |-> !stat_busy);

    p_count_match_r7: assert property (@(posedge clk) disable iff (!rst_n)
        scan_done |-> (bad_count == CNT_W'($countones(bad_map))));

    p_flags_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(scan_done && scan_err));

    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !scan_busy |-> !spi_cs);

    p_done_last_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scan_done) |-> ($past(blk) == LAST_BLK && !scan_busy));

endmodule

// File: tb/nbs_bbt_scanner_bench.sv
`timescale 1ns/1ps
module nbs_bbt_scanner_bench;

    localparam int NB = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        spi_cs, spi_req, spi_ack;
    logic [7:0]  spi_tx, spi_rx;
    logic [NB-1:0] bad_map;
    logic [4:0]  bad_count;
    logic        scan_busy, scan_done, scan_err;

    int checks = 0;
    int fails  = 0;

    // Device model configuration, one entry per block.
    logic [7:0]  b0_cfg  [NB];
    logic [31:0] sig_cfg [NB];
    int          busy_cfg[NB];

    // Device model state.
    int         bidx;
    logic [7:0] op;
    logic [7:0] row_hi;
    int         cur_blk;
    int         busy_left;
    int         exp_blk;
    int         loads;
    int         spares;

    always #2.5 clk = ~clk;

    nbs_bbt_scanner #(.NUM_BLOCKS(NB), .PAGES_SHIFT(6), .POLL_LIMIT(100)) u_nbs_bbt_scanner (
        .clk(clk), .rst_n(rst_n), .start(start),
        .spi_cs(spi_cs), .spi_req(spi_req), .spi_tx(spi_tx),
        .spi_ack(spi_ack), .spi_rx(spi_rx),
        .bad_map(bad_map), .bad_count(bad_count),
        .scan_busy(scan_busy), .scan_done(scan_done), .scan_err(scan_err)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic cfg_default();
        for (int i = 0; i < NB; i++) begin
            b0_cfg[i]   = 8'hFF;
            sig_cfg[i]  = 32'h0;
            busy_cfg[i] = 0;
        end
    endtask

    // Device model: answers each byte request on the falling edge.
    initial begin
        spi_ack = 1'b0;
        spi_rx  = 8'hFF;
        bidx = 0; op = 8'h00; row_hi = 8'h00; cur_blk = 0; busy_left = 0;
        exp_blk = 0; loads = 0; spares = 0;
        forever begin
            @(negedge clk);
            if (spi_req && !spi_cs) chk(0, "R10", "req outside frame", 1, 0);
            if (!spi_cs) begin
                bidx    = 0;
                spi_ack = 1'b0;
            end else if (spi_req && !spi_ack) begin
                spi_rx = 8'hFF;
                if (bidx == 0) op = spi_tx;
                if (op == 8'h13) begin
                    if (bidx == 1) chk(spi_tx == 8'h00, "R2", "load byte1", spi_tx, 0);
                    if (bidx == 2) row_hi = spi_tx;
                    if (bidx == 3) begin
                        chk({row_hi, spi_tx} == 16'(exp_blk << 6), "R2", "load row",
                            {row_hi, spi_tx}, exp_blk << 6);
                        cur_blk   = {row_hi, spi_tx} >> 6;
                        if (cur_blk >= NB) cur_blk = NB - 1;
                        busy_left = busy_cfg[cur_blk];
                        exp_blk++;
                        loads++;
                    end
                end else if (op == 8'h0F) begin
                    if (bidx == 1) chk(spi_tx == 8'hC0, "R3", "status reg", spi_tx, 8'hC0);
                    if (bidx == 2) begin
                        if (busy_left > 0) begin
                            spi_rx = 8'h0D;
                            busy_left--;
                        end else begin
                            spi_rx = 8'h0C;
                        end
                    end
                end else if (op == 8'h03) begin
                    if (bidx == 1) chk(spi_tx == 8'h08, "R4", "spare byte1", spi_tx, 8'h08);
                    if (bidx == 2 || bidx == 3)
                        chk(spi_tx == 8'h00, "R4", "spare addr byte", spi_tx, 0);
                    if (bidx == 4) begin
                        chk(busy_left == 0, "R3", "spare read while busy", busy_left, 0);
                        spares++;
                    end
                    if (bidx >= 4) begin
                        case (bidx - 4)
                            0:  spi_rx = b0_cfg[cur_blk];
                            8:  spi_rx = sig_cfg[cur_blk][31:24];
                            9:  spi_rx = sig_cfg[cur_blk][23:16];
                            10: spi_rx = sig_cfg[cur_blk][15:8];
                            11: spi_rx = sig_cfg[cur_blk][7:0];
                            default: spi_rx = 8'h5A;
                        endcase
                    end
                    if (bidx > 19) chk(0, "R4", "spare frame too long", bidx, 19);
                end else begin
                    chk(0, "R2", "unknown opcode", op, 8'h13);
                end
                spi_ack = 1'b1;
                bidx++;
            end else begin
                spi_ack = 1'b0;
            end
        end
    end

    // Pulse start, check the cleared state, wait for the scan to end.
    task automatic run_scan(input bit inject);
        int cyc;
        exp_blk = 0; loads = 0; spares = 0;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        chk(scan_busy == 1'b1, "R1", "busy after start", scan_busy, 1);
        chk(bad_map == '0, "R1", "map cleared", bad_map, 0);
        chk(bad_count == 0, "R1", "count cleared", bad_count, 0);
        chk(!scan_done && !scan_err, "R1", "flags cleared", {scan_done, scan_err}, 0);
        cyc = 0;
        while (scan_busy && cyc < 40000) begin
            if (scan_done) chk(0, "R9", "done while busy", 1, 0);
            if (inject && cyc == 40) start = 1'b1;
            if (inject && cyc == 41) start = 1'b0;
            @(negedge clk);
            cyc++;
        end
        start = 1'b0;
    endtask

    task automatic t_reset();
        chk(!spi_cs && !spi_req, "R10", "port idle at reset", {spi_cs, spi_req}, 0);
        chk(!scan_busy && !scan_done && !scan_err, "R9", "flags at reset",
            {scan_busy, scan_done, scan_err}, 0);
        chk(bad_map == '0 && bad_count == 0, "R7", "map at reset", bad_map, 0);
    endtask

    task automatic t_clean();
        cfg_default();
        run_scan(0);
        chk(scan_done && !scan_err, "R9", "clean done", {scan_done, scan_err}, 2);
        chk(bad_map == '0, "R5", "clean map", bad_map, 0);
        chk(loads == NB, "R2", "clean load count", loads, NB);
        chk(spares == NB, "R4", "clean spare count", spares, NB);
    endtask

    task automatic t_mixed();
        cfg_default();
        b0_cfg[1]  = 8'h00;
        b0_cfg[5]  = 8'hFE;
        sig_cfg[3] = 32'hDEADBEEF;
        b0_cfg[7]  = 8'h00;  sig_cfg[7] = 32'hDEADBEEF;
        sig_cfg[9]  = 32'hDEADBEEE;
        sig_cfg[10] = 32'hEFBEADDE;
        sig_cfg[11] = 32'h5EADBEEF;
        sig_cfg[14] = 32'hDEADBEEF;  busy_cfg[14] = 99;
        busy_cfg[2]  = 3;
        busy_cfg[12] = 99;
        run_scan(1);
        chk(scan_done && !scan_err, "R9", "mixed done", {scan_done, scan_err}, 2);
        chk(bad_map[1] && bad_map[5], "R5", "factory marks", bad_map, 16'h40AA);
        chk(bad_map[3] && bad_map[14], "R6", "signature marks", bad_map, 16'h40AA);
        chk(!bad_map[9] && !bad_map[10] && !bad_map[11], "R6", "near-miss signatures",
            bad_map, 16'h40AA);
        chk(bad_map == 16'h40AA, "R6", "mixed map", bad_map, 16'h40AA);
        chk(bad_count == 5, "R7", "mixed count", bad_count, 5);
        chk(loads == NB && spares == NB, "R1", "start during scan ignored", loads, NB);
        chk(bad_map[12] == 1'b0 && scan_done, "R3", "ready on 100th poll", bad_map[12], 0);
    endtask

    task automatic t_rescan();
        cfg_default();
        run_scan(0);
        chk(bad_map == '0 && bad_count == 0, "R1", "rescan result", bad_map, 0);
        chk(scan_done, "R9", "rescan done", scan_done, 1);
    endtask

    task automatic t_timeout();
        cfg_default();
        b0_cfg[2]   = 8'h00;
        busy_cfg[4] = 100;
        run_scan(0);
        chk(scan_err && !scan_done && !scan_busy, "R8", "timeout flags",
            {scan_busy, scan_done, scan_err}, 1);
        chk(bad_map == 16'h0004, "R8", "map kept", bad_map, 16'h0004);
        chk(bad_count == 1, "R7", "timeout count", bad_count, 1);
        chk(loads == 5 && spares == 4, "R8", "frames stop", loads * 100 + spares, 504);
        repeat (20) @(negedge clk);
        chk(loads == 5 && !spi_cs, "R8", "no frame after stop", loads, 5);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_clean();
        t_mixed();
        t_rescan();
        t_timeout();
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

endmodule